// File: doc/BRIEF.md
# Fetch-Address Target Predictor

This block sits beside the fetch stage. It takes the current fetch address and, in the same cycle, returns the address to fetch next. The block never sees the fetched instruction. It treats any address whose tag is stored in its table as a predicted branch. Each stored entry holds a direction bit and a word-aligned target.

- If the entry is marked taken, the next fetch address is that target.
- Otherwise, including every address with no entry, the next fetch address is the sequential word, fetch address plus four.

The table is direct-mapped with one entry per index and no associativity.

When a branch resolves later in the pipeline, the core reports it on the update pins.

- A taken outcome allocates the entry for that address, or overwrites whatever occupied its index.
- A not-taken outcome whose address is already present clears only the direction bit of that entry.

Lookup has no handshake and fetch may present a new address every cycle. The update port is valid-only and has no back-pressure: an update is accepted in any cycle where `upd_valid` is high. An update changes the table at the clock edge. The first lookup to see the change is the one in the following cycle.

Top module: `fetch_target_buffer`

## Requirements
- R1: A synchronous active-high `rst` invalidates every entry. From the first clock edge with `rst` high onward, until a taken update is applied, every lookup reports `pred_hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R2: For a table of 2^IDX_W entries, the entry index is `fetch_pc[IDX_W+1:2]`. The tag is `fetch_pc[PC_W-1:IDX_W+2]`. Two addresses that share an index but differ in tag never hit on each other's entry.
- R3: A lookup that hits an entry marked taken drives `pred_hit`=1, `pred_taken`=1 and `next_pc` equal to the stored target, all combinationally within the cycle.
- R4: A lookup with no valid entry of matching tag drives `pred_hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R5: A lookup that hits an entry marked not taken drives `pred_hit`=1, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R6: An update with `upd_taken`=1 writes the entry at the index of `upd_pc`. It sets valid and taken, stores the tag of `upd_pc` and stores `upd_target`. Any previous occupant of that index is replaced.
- R7: An update with `upd_taken`=0 whose `upd_pc` hits a valid entry clears that entry's taken bit. The entry stays valid, so it keeps reporting `pred_hit`=1.
- R8: An update with `upd_taken`=0 whose `upd_pc` does not hit changes nothing. In particular, an entry of a different tag at the same index keeps its prediction.
- R9: A lookup in the same cycle as an update sees the table as it was before that update. The update is visible from the next cycle.
- R10: Stored targets are word aligned. Bits [1:0] of `upd_target` are discarded, and a taken prediction drives `next_pc[1:0]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Address matched an entry (predicted branch) |
| pred_taken | output | 1 | Matched entry predicts taken |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |
| upd_target | input | PC_W | Resolved target address |

## Verification
A corrupted valid bit, tag or direction bit shows up at the ports on the first lookup of that address. The effect appears in the same cycle as a wrong `pred_hit` or `pred_taken` and a `next_pc` that is off by a redirect. It cannot hide for long, because the bench checks all three outputs every cycle against a behavioural model of the table.

A write landing at the wrong index or with the wrong tag only surfaces when the affected address is next fetched. For that reason the stimulus revisits a small pool of 64 addresses, four tags over every index, so that every entry is read back within a few dozen cycles of being written. Aliasing pairs and same-cycle lookup-and-update cases are directed explicitly.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action the update controller asks the table to perform on one entry.
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_ALLOC = 2'd1,
    WR_CLEAR = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  // Word offset bits [1:0] take no part in the lookup.
  assign idx = pc[IDX_W+1:2];
  assign tag = pc[PC_W-1:IDX_W+2];

endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2,
  localparam int TGT_W = PC_W - 2,
  localparam int NENT  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  // lookup read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_taken,
  output logic [TGT_W-1:0] rd_tgt,
  // update read port (tag check before writing)
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_valid,
  output logic [TAG_W-1:0] chk_tag,
  // write port
  input  wr_kind_e         wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt
);

  logic [NENT-1:0]  ent_valid;
  logic [NENT-1:0]  ent_taken;
  logic [TAG_W-1:0] ent_tag [NENT];
  logic [TGT_W-1:0] ent_tgt [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic sel;
    assign sel = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[e] <= 1'b0;
        ent_taken[e] <= 1'b0;
      end else if (sel) begin
        unique case (wr_kind)
          WR_ALLOC: begin
            ent_valid[e] <= 1'b1;
            ent_taken[e] <= 1'b1;
          end
          WR_CLEAR: ent_taken[e] <= 1'b0;
          default:  ;
        endcase
      end
    end

    // Payload carries no reset; the valid bit qualifies it.
    always_ff @(posedge clk) begin
      if (sel && wr_kind == WR_ALLOC) begin
        ent_tag[e] <= wr_tag;
        ent_tgt[e] <= wr_tgt;
      end
    end
  end

  assign rd_valid  = ent_valid[rd_idx];
  assign rd_taken  = ent_taken[rd_idx];
  assign rd_tag    = ent_tag[rd_idx];
  assign rd_tgt    = ent_tgt[rd_idx];
  assign chk_valid = ent_valid[chk_idx];
  assign chk_tag   = ent_tag[chk_idx];

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             cur_valid,
  input  logic [TAG_W-1:0] cur_tag,
  output wr_kind_e         wr_kind
);

  logic present;
  assign present = cur_valid && (cur_tag == upd_tag);

  always_comb begin
    wr_kind = WR_NONE;
    if (upd_valid) begin
      if (upd_taken)    wr_kind = WR_ALLOC;
      else if (present) wr_kind = WR_CLEAR;
    end
  end

endmodule

// File: rtl/btb_select.sv
module btb_select #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2,
  localparam int TGT_W = PC_W - 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [TAG_W-1:0] pc_tag,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic             ent_taken,
  input  logic [TGT_W-1:0] ent_tgt,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);

  assign hit     = ent_valid && (ent_tag == pc_tag);
  assign taken   = hit && ent_taken;
  assign next_pc = taken ? {ent_tgt, 2'b00} : pc + PC_W'(4);

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int TGT_W = PC_W - 2;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             rd_valid, rd_taken, chk_valid;
  logic [TAG_W-1:0] rd_tag, chk_tag;
  logic [TGT_W-1:0] rd_tgt;
  wr_kind_e         wr_kind;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_fetch (
    .pc(fetch_pc), .idx(f_idx), .tag(f_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_upd (
    .pc(upd_pc), .idx(u_idx), .tag(u_tag)
  );

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (f_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_taken (rd_taken),
    .rd_tgt   (rd_tgt),
    .chk_idx  (u_idx),
    .chk_valid(chk_valid),
    .chk_tag  (chk_tag),
    .wr_kind  (wr_kind),
    .wr_idx   (u_idx),
    .wr_tag   (u_tag),
    .wr_tgt   (upd_target[PC_W-1:2])
  );

  btb_update_ctl #(.TAG_W(TAG_W)) u_upd (
    .upd_valid(upd_valid),
    .upd_taken(upd_taken),
    .upd_tag  (u_tag),
    .cur_valid(chk_valid),
    .cur_tag  (chk_tag),
    .wr_kind  (wr_kind)
  );

  btb_select #(.PC_W(PC_W), .IDX_W(IDX_W)) u_sel (
    .pc       (fetch_pc),
    .pc_tag   (f_tag),
    .ent_valid(rd_valid),
    .ent_tag  (rd_tag),
    .ent_taken(rd_taken),
    .ent_tgt  (rd_tgt),
    .hit      (pred_hit),
    .taken    (pred_taken),
    .next_pc  (next_pc)
  );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);

  // R1: one edge of reset leaves no entry able to hit
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !pred_hit);

  // R3: a taken prediction only comes from a hit
  a_r3_taken_from_hit: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  // R4: a miss falls through to the next word
  a_r4_miss_sequential: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (next_pc == fetch_pc + PC_W'(4)));

  // R5: a hit predicted not taken falls through as well
  a_r5_nt_sequential: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && !pred_taken) |-> (next_pc == fetch_pc + PC_W'(4)));

  // R6 / R9: a taken update is seen by a lookup of the same address next cycle
  a_r6_alloc_visible: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) |=>
      ((fetch_pc != $past(upd_pc)) ||
       (pred_hit && pred_taken && next_pc == {$past(upd_target[PC_W-1:2]), 2'b00})));

  // R7: a not-taken update of a present entry keeps it valid but not taken
  a_r7_clear_keeps_entry: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && pred_hit && fetch_pc == upd_pc) |=>
      ((fetch_pc != $past(fetch_pc)) || (pred_hit && !pred_taken)));

  // R10: redirected addresses are word aligned
  a_r10_aligned_target: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> (next_pc[1:0] == 2'b00));

endmodule

bind fetch_target_buffer btb_checker #(.PC_W(PC_W)) u_btb_checker (
  .clk       (clk),
  .rst       (rst),
  .fetch_pc  (fetch_pc),
  .pred_hit  (pred_hit),
  .pred_taken(pred_taken),
  .next_pc   (next_pc),
  .upd_valid (upd_valid),
  .upd_pc    (upd_pc),
  .upd_taken (upd_taken),
  .upd_target(upd_target)
);

// File: tb/tb_fetch_target_buffer.sv
module tb_fetch_target_buffer;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int NENT  = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] fetch_pc;
  logic            pred_hit, pred_taken;
  logic [PC_W-1:0] next_pc;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;
  logic [PC_W-1:0] upd_target;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model: map from index to the full address/target last stored.
  bit            m_valid [int];
  bit            m_taken [int];
  logic [31:0]   m_pc    [int];
  logic [31:0]   m_tgt   [int];

  always #5 clk = ~clk;

  fetch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic int idx_of(logic [31:0] a);
    return int'((a >> 2) % NENT);
  endfunction

  function automatic bit model_hit(logic [31:0] a);
    int i = idx_of(a);
    if (!m_valid.exists(i) || !m_valid[i]) return 0;
    return (m_pc[i] >> (IDX_W + 2)) == (a >> (IDX_W + 2));
  endfunction

  task automatic step(input logic [31:0] pc, input bit uv, input logic [31:0] upc,
                      input bit ut, input logic [31:0] utgt, input bit r,
                      input string req);
    bit          eh, et;
    logic [31:0] en;
    @(negedge clk);
    rst = r; fetch_pc = pc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
    #1;
    eh = model_hit(pc);
    et = eh && m_taken[idx_of(pc)];
    en = et ? {m_tgt[idx_of(pc)][31:2], 2'b00} : pc + 32'd4;
    checks++;
    if (pred_hit !== eh || pred_taken !== et || next_pc !== en) begin
      errors++;
      $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h, expected hit=%b taken=%b next=%h",
               req, pc, pred_hit, pred_taken, next_pc, eh, et, en);
    end
    @(posedge clk);
    if (r) begin
      foreach (m_valid[k]) m_valid[k] = 0;
    end else if (uv) begin
      int i = idx_of(upc);
      if (ut) begin
        m_valid[i] = 1; m_taken[i] = 1; m_pc[i] = upc; m_tgt[i] = utgt;
      end else if (model_hit(upc)) begin
        m_taken[i] = 0;
      end
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; fetch_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0; upd_target = 0;
    // R1: reset held, table empty; a taken update during reset is discarded
    step(32'h100, 0, 0, 0, 0, 1, "R1");
    step(32'h100, 1, 32'h100, 1, 32'h4000, 1, "R1");
    step(32'h100, 0, 0, 0, 0, 0, "R1");
    // R4: empty lookups
    look(32'h0, "R4");
    look(32'hFFFF_FFFC, "R4");
    // R9: lookup in the same cycle as the allocating update misses
    step(32'h100, 1, 32'h100, 1, 32'h2003, 0, "R9");
    // R3 / R10: hit taken, target low bits dropped
    look(32'h100, "R3");
    look(32'h100, "R10");
    // R2: same index, other tag
    look(32'h140, "R2");
    look(32'h104, "R2");
    // R7 / R9: clear taken bit; same-cycle lookup still sees taken
    step(32'h100, 1, 32'h100, 0, 32'h0, 0, "R9");
    look(32'h100, "R7");
    look(32'h100, "R5");
    // R8: not-taken update of alias misses and leaves entry alone
    step(32'h140, 1, 32'h140, 0, 32'h0, 0, "R8");
    look(32'h100, "R8");
    look(32'h140, "R8");
    // R6: taken alias overwrites the index
    step(32'h200, 1, 32'h140, 1, 32'h8000, 0, "R6");
    look(32'h100, "R6");
    look(32'h140, "R6");
    // R6: retaking re-sets the taken bit after a clear
    step(32'h140, 1, 32'h140, 0, 0, 0, "R7");
    step(32'h140, 1, 32'h140, 1, 32'h9000, 0, "R6");
    look(32'h140, "R6");
    // mixed traffic over a 64-address pool: R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a = 32'h1000 + (($urandom % 64) << 2);
      logic [31:0] b = 32'h1000 + (($urandom % 64) << 2);
      bit          u = ($urandom % 2) == 1;
      step(a, u, b, ($urandom % 3) != 0, $urandom, 0, "R3");
    end
    // R1: reset mid-run empties a populated table
    step(32'h1000, 0, 0, 0, 0, 1, "R1");
    for (int n = 0; n < 64; n++) look(32'h1000 + (n << 2), "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule